// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit processor core whose register view changes with the operating mode. It holds 37 physical 32-bit registers. Sixteen general indices (index 15 is the program counter), one current status register and one saved status register are mapped onto them according to a 5-bit mode code supplied by the core. Two combinational read ports and one clocked write port share the 4-bit index space. A separate port reads and writes the saved status register of the current mode, and a side port loads the saved status register of any chosen mode, so that exception entry can save the old status in the same cycle that the mode changes.

The mode decoder is the single piece of state selection in the block. It takes seven legal codes, user (10000), fast interrupt (10001), interrupt (10010), supervisor (10011), abort (10111), undefined (11011) and system (11111), and maps them onto six register banks: the common bank (user and system), the fast bank, and the interrupt, supervisor, abort and undefined banks. Any other code falls back to the common bank and raises an error flag. Only user mode is unprivileged, but privilege plays no part in register selection. The physical index is chosen by the bank and the architectural index: R0–R7 and R15 always use the common copy. R8–R12 use a private copy only in the fast bank. R13 and R14 use a private copy in each of the five exception banks.

Top module: `banked_regfile`

## Requirements
- R1: After reset every physical register reads zero, through every port and in every mode.
- R2: Indices 0–7 and 15 name one shared register each, so a value written in any mode is read back in every other mode.
- R3: Indices 8–12 have a private copy in fast-interrupt mode (10001). All other modes share one copy, so writes in either group leave the other untouched.
- R4: Indices 13 and 14 have a private copy in each of fast-interrupt, interrupt, supervisor, abort and undefined modes. User and system modes share a single copy.
- R5: Both read ports return the addressed register combinationally and independently in the same cycle. A write takes effect at the next rising clock edge, and until then reads of the written index return the old value.
- R6: In the five exception modes the saved-status port reads and writes that mode's private saved status register. In user or system mode it reads zero and a write through it changes no register.
- R7: A mode code outside the seven legal codes drives mode_err high and selects registers exactly as user mode does. Legal codes drive mode_err low.
- R8: The side port writes the saved status register of the mode named on xspsr_mode at the clock edge, whatever the current mode. If that target is user, system or illegal, the write is ignored.
- R9: When the saved-status port and the side port hit the same saved status register in one cycle, the side port's data is stored. When they hit different registers, both writes take effect.
- R10: The current status register is one register shared by every mode and is written through its own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current mode code |
| mode_err | output | 1 | High when mode_i is not a legal code |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write architectural index |
| wr_data | input | 32 | General write data |
| cpsr_we | input | 1 | Current status write enable |
| cpsr_wdata | input | 32 | Current status write data |
| cpsr_rdata | output | 32 | Current status read data |
| spsr_we | input | 1 | Saved status write enable, current mode |
| spsr_wdata | input | 32 | Saved status write data, current mode |
| spsr_rdata | output | 32 | Saved status of current mode (zero in user/system) |
| xspsr_we | input | 1 | Side-port saved status write enable |
| xspsr_mode | input | 5 | Mode code whose saved status the side port writes |
| xspsr_wdata | input | 32 | Side-port saved status write data |

## Verification
Two functions can land in the same cycle: a saved-status write through the current-mode port and a side-port write at exception entry. The bench provokes the collision in supervisor mode with both ports aimed at the supervisor copy and different data, and expects the side port's value afterwards. It then sets abort as the current mode and undefined as the side-port target, and expects each mode to read back its own value. A mode change in the same cycle as a side write is also covered: the bench reads the new mode's saved status right after the edge and expects the side-port data.

// File: rtl/bkrf_pkg.sv
package bkrf_pkg;

    localparam int N_PHYS   = 37;
    localparam int PHYS_W   = $clog2(N_PHYS);
    localparam int IDX_W    = 4;
    localparam int MODE_W   = 5;

    // physical layout
    localparam int PH_FIQ_BASE  = 16;   // fast bank R8..R14
    localparam int PH_IRQ_BASE  = 23;   // R13,R14
    localparam int PH_SVC_BASE  = 25;
    localparam int PH_ABT_BASE  = 27;
    localparam int PH_UND_BASE  = 29;
    localparam int PH_CPSR      = 31;
    localparam int PH_SPSR_BASE = 32;   // fast, irq, svc, abt, und

    typedef enum logic [MODE_W-1:0] {
        MD_USR = 5'b10000,
        MD_FIQ = 5'b10001,
        MD_IRQ = 5'b10010,
        MD_SVC = 5'b10011,
        MD_ABT = 5'b10111,
        MD_UND = 5'b11011,
        MD_SYS = 5'b11111
    } mode_code_e;

    typedef enum logic [2:0] {
        BK_COM = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    // true for legal codes that own a saved status register
    function automatic logic code_banked(input logic [MODE_W-1:0] code);
        case (code)
            MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

    function automatic logic [PHYS_W-1:0] sp_lr_base(input bank_e bk);
        case (bk)
            BK_FIQ:  return PHYS_W'(PH_FIQ_BASE + 5);
            BK_IRQ:  return PHYS_W'(PH_IRQ_BASE);
            BK_SVC:  return PHYS_W'(PH_SVC_BASE);
            BK_ABT:  return PHYS_W'(PH_ABT_BASE);
            BK_UND:  return PHYS_W'(PH_UND_BASE);
            default: return PHYS_W'(13);
        endcase
    endfunction

    function automatic logic [PHYS_W-1:0] spsr_slot(input bank_e bk);
        case (bk)
            BK_FIQ:  return PHYS_W'(PH_SPSR_BASE + 0);
            BK_IRQ:  return PHYS_W'(PH_SPSR_BASE + 1);
            BK_SVC:  return PHYS_W'(PH_SPSR_BASE + 2);
            BK_ABT:  return PHYS_W'(PH_SPSR_BASE + 3);
            BK_UND:  return PHYS_W'(PH_SPSR_BASE + 4);
            default: return PHYS_W'(PH_CPSR);
        endcase
    endfunction

endpackage

// File: rtl/bkrf_mode_dec.sv
module bkrf_mode_dec
    import bkrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_code,
    output bank_e             bank,
    output logic              illegal
);

    always_comb begin
        bank    = BK_COM;
        illegal = 1'b0;
        case (mode_code)
            MD_USR:  bank = BK_COM;
            MD_SYS:  bank = BK_COM;
            MD_FIQ:  bank = BK_FIQ;
            MD_IRQ:  bank = BK_IRQ;
            MD_SVC:  bank = BK_SVC;
            MD_ABT:  bank = BK_ABT;
            MD_UND:  bank = BK_UND;
            default: begin
                bank    = BK_COM;
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/bkrf_addr_map.sv
module bkrf_addr_map
    import bkrf_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  bank_e             bank,
    output logic [PHYS_W-1:0] phys
);

    logic is_hi_gp;   // R8..R12
    logic is_sp_lr;   // R13,R14

    assign is_hi_gp = (idx >= IDX_W'(8)) && (idx <= IDX_W'(12));
    assign is_sp_lr = (idx == IDX_W'(13)) || (idx == IDX_W'(14));

    always_comb begin
        phys = PHYS_W'(idx);
        if (bank == BK_FIQ && is_hi_gp) begin
            phys = PHYS_W'(PH_FIQ_BASE) + PHYS_W'(idx) - PHYS_W'(8);
        end else if (bank != BK_COM && is_sp_lr) begin
            phys = sp_lr_base(bank) + PHYS_W'(idx) - PHYS_W'(13);
        end
    end

endmodule

// File: rtl/bkrf_reg.sv
module bkrf_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bkrf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    output logic              mode_err,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DW-1:0]     rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DW-1:0]     rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              cpsr_we,
    input  logic [DW-1:0]     cpsr_wdata,
    output logic [DW-1:0]     cpsr_rdata,
    input  logic              spsr_we,
    input  logic [DW-1:0]     spsr_wdata,
    output logic [DW-1:0]     spsr_rdata,
    input  logic              xspsr_we,
    input  logic [MODE_W-1:0] xspsr_mode,
    input  logic [DW-1:0]     xspsr_wdata
);

    bank_e              cur_bank, tgt_bank;
    logic               cur_illegal, tgt_illegal;
    logic [PHYS_W-1:0]  rd_a_phys, rd_b_phys, wr_phys;
    logic [DW-1:0]      regs   [N_PHYS];
    logic               we_vec [N_PHYS];
    logic [DW-1:0]      wd_vec [N_PHYS];

    bkrf_mode_dec u_cur_dec (.mode_code(mode_i),     .bank(cur_bank), .illegal(cur_illegal));
    bkrf_mode_dec u_tgt_dec (.mode_code(xspsr_mode), .bank(tgt_bank), .illegal(tgt_illegal));

    bkrf_addr_map u_map_a (.idx(rd_a_idx), .bank(cur_bank), .phys(rd_a_phys));
    bkrf_addr_map u_map_b (.idx(rd_b_idx), .bank(cur_bank), .phys(rd_b_phys));
    bkrf_addr_map u_map_w (.idx(wr_idx),   .bank(cur_bank), .phys(wr_phys));

    // write steering; side port is applied last so it wins a shared target
    always_comb begin
        for (int p = 0; p < N_PHYS; p++) begin
            we_vec[p] = 1'b0;
            wd_vec[p] = '0;
        end
        if (wr_en) begin
            we_vec[wr_phys] = 1'b1;
            wd_vec[wr_phys] = wr_data;
        end
        if (cpsr_we) begin
            we_vec[PH_CPSR] = 1'b1;
            wd_vec[PH_CPSR] = cpsr_wdata;
        end
        if (spsr_we && cur_bank != BK_COM) begin
            we_vec[spsr_slot(cur_bank)] = 1'b1;
            wd_vec[spsr_slot(cur_bank)] = spsr_wdata;
        end
        if (xspsr_we && !tgt_illegal && tgt_bank != BK_COM) begin
            we_vec[spsr_slot(tgt_bank)] = 1'b1;
            wd_vec[spsr_slot(tgt_bank)] = xspsr_wdata;
        end
    end

    for (genvar g = 0; g < N_PHYS; g++) begin : g_cell
        bkrf_reg #(.DW(DW)) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (we_vec[g]),
            .d    (wd_vec[g]),
            .q    (regs[g])
        );
    end

    assign rd_a_data  = regs[rd_a_phys];
    assign rd_b_data  = regs[rd_b_phys];
    assign cpsr_rdata = regs[PH_CPSR];
    assign spsr_rdata = (cur_bank != BK_COM) ? regs[spsr_slot(cur_bank)] : '0;
    assign mode_err   = cur_illegal;

endmodule

// File: rtl/bkrf_checks.sv
module bkrf_checks
    import bkrf_pkg::*;
#(
    parameter int DW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_i,
    input logic              mode_err,
    input logic [IDX_W-1:0]  rd_a_idx,
    input logic [DW-1:0]     rd_a_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [DW-1:0]     wr_data,
    input logic              cpsr_we,
    input logic [DW-1:0]     cpsr_wdata,
    input logic [DW-1:0]     cpsr_rdata,
    input logic              spsr_we,
    input logic [DW-1:0]     spsr_wdata,
    input logic [DW-1:0]     spsr_rdata,
    input logic              xspsr_we,
    input logic [MODE_W-1:0] xspsr_mode,
    input logic [DW-1:0]     xspsr_wdata
);

    p_common_spsr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_USR || mode_i == MD_SYS) |-> spsr_rdata == '0);

    p_illegal_as_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> spsr_rdata == '0);

    p_write_then_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(wr_idx) == rd_a_idx && $past(mode_i) == mode_i)
        |-> rd_a_data == $past(wr_data));

    p_cpsr_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cpsr_we) |-> cpsr_rdata == $past(cpsr_wdata));

    p_side_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(xspsr_we) && $past(xspsr_mode) == mode_i && code_banked(mode_i))
        |-> spsr_rdata == $past(xspsr_wdata));

    p_spsr_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spsr_we) && !$past(xspsr_we) && $past(mode_i) == mode_i && code_banked(mode_i))
        |-> spsr_rdata == $past(spsr_wdata));

    p_spsr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(spsr_we) && !$past(xspsr_we) && $stable(mode_i)) |-> $stable(spsr_rdata));

endmodule

bind banked_regfile bkrf_checks #(.DW(DW)) u_bkrf_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .mode_err   (mode_err),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .cpsr_we    (cpsr_we),
    .cpsr_wdata (cpsr_wdata),
    .cpsr_rdata (cpsr_rdata),
    .spsr_we    (spsr_we),
    .spsr_wdata (spsr_wdata),
    .spsr_rdata (spsr_rdata),
    .xspsr_we   (xspsr_we),
    .xspsr_mode (xspsr_mode),
    .xspsr_wdata(xspsr_wdata)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;

    localparam int CLK_PERIOD = 10;

    localparam logic [4:0] C_USR = 5'b10000;
    localparam logic [4:0] C_FIQ = 5'b10001;
    localparam logic [4:0] C_IRQ = 5'b10010;
    localparam logic [4:0] C_SVC = 5'b10011;
    localparam logic [4:0] C_ABT = 5'b10111;
    localparam logic [4:0] C_UND = 5'b11011;
    localparam logic [4:0] C_SYS = 5'b11111;
    localparam logic [4:0] C_BAD = 5'b00110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = C_USR;
    logic        mode_err;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        cpsr_we = 1'b0;
    logic [31:0] cpsr_wdata = '0, cpsr_rdata;
    logic        spsr_we = 1'b0;
    logic [31:0] spsr_wdata = '0, spsr_rdata;
    logic        xspsr_we = 1'b0;
    logic [4:0]  xspsr_mode = C_USR;
    logic [31:0] xspsr_wdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile u_banked_regfile (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_err(mode_err),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_rdata(cpsr_rdata),
        .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_rdata(spsr_rdata),
        .xspsr_we(xspsr_we), .xspsr_mode(xspsr_mode), .xspsr_wdata(xspsr_wdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic gwrite(input logic [4:0] md, input logic [3:0] idx, input logic [31:0] v);
        mode_i = md; wr_idx = idx; wr_data = v; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic gread(input logic [4:0] md, input logic [3:0] idx, output logic [31:0] v);
        mode_i = md; rd_a_idx = idx;
        #1;
        v = rd_a_data;
    endtask

    task automatic sread(input logic [4:0] md, output logic [31:0] v);
        mode_i = md;
        #1;
        v = spsr_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) begin
            gread(C_USR, 4'(i), v); chk("R1 usr gpr", v, 0);
            gread(C_FIQ, 4'(i), v); chk("R1 fiq gpr", v, 0);
        end
        sread(C_SVC, v); chk("R1 svc spsr", v, 0);
        chk("R1 cpsr", cpsr_rdata, 0);
    endtask

    task automatic t_shared_low();
        logic [31:0] v;
        gwrite(C_USR, 4'd3, 32'h0000_0333);
        gwrite(C_FIQ, 4'd15, 32'h0000_8000);
        gread(C_FIQ, 4'd3, v);  chk("R2 r3 in fiq", v, 32'h333);
        gread(C_SVC, 4'd3, v);  chk("R2 r3 in svc", v, 32'h333);
        gread(C_UND, 4'd15, v); chk("R2 pc in und", v, 32'h8000);
        gread(C_USR, 4'd15, v); chk("R2 pc in usr", v, 32'h8000);
    endtask

    task automatic t_fiq_bank();
        logic [31:0] v;
        gwrite(C_USR, 4'd10, 32'hAAAA_0010);
        gwrite(C_FIQ, 4'd10, 32'hBBBB_0010);
        gwrite(C_IRQ, 4'd12, 32'hCCCC_0012);
        gread(C_FIQ, 4'd10, v); chk("R3 fiq r10", v, 32'hBBBB_0010);
        gread(C_USR, 4'd10, v); chk("R3 usr r10", v, 32'hAAAA_0010);
        gread(C_IRQ, 4'd10, v); chk("R3 irq r10", v, 32'hAAAA_0010);
        gread(C_SYS, 4'd12, v); chk("R3 sys r12", v, 32'hCCCC_0012);
        gread(C_FIQ, 4'd12, v); chk("R3 fiq r12", v, 0);
    endtask

    task automatic t_sp_lr();
        logic [31:0] v;
        logic [4:0] md [6] = '{C_USR, C_FIQ, C_IRQ, C_SVC, C_ABT, C_UND};
        for (int m = 0; m < 6; m++) begin
            gwrite(md[m], 4'd13, 32'h1300_0000 + 32'(m));
            gwrite(md[m], 4'd14, 32'h1400_0000 + 32'(m));
        end
        for (int m = 0; m < 6; m++) begin
            gread(md[m], 4'd13, v); chk("R4 sp per mode", v, 32'h1300_0000 + 32'(m));
            gread(md[m], 4'd14, v); chk("R4 lr per mode", v, 32'h1400_0000 + 32'(m));
        end
        gwrite(C_SYS, 4'd13, 32'h5555_0013);
        gread(C_USR, 4'd13, v); chk("R4 sys sp seen in usr", v, 32'h5555_0013);
        gread(C_SVC, 4'd13, v); chk("R4 svc sp untouched", v, 32'h1300_0003);
    endtask

    task automatic t_dual_read();
        mode_i = C_USR;
        rd_a_idx = 4'd3; rd_b_idx = 4'd15;
        #1;
        chk("R5 port a", rd_a_data, 32'h333);
        chk("R5 port b", rd_b_data, 32'h8000);
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hDEAD_0003;
        #1;
        chk("R5 old before edge", rd_a_data, 32'h333);
        tick();
        wr_en = 1'b0;
        #1;
        chk("R5 new after edge", rd_a_data, 32'hDEAD_0003);
        chk("R5 port b unaffected", rd_b_data, 32'h8000);
    endtask

    task automatic t_spsr();
        logic [31:0] v;
        mode_i = C_SVC; spsr_wdata = 32'h0000_0053; spsr_we = 1'b1;
        tick(); spsr_we = 1'b0;
        mode_i = C_ABT; spsr_wdata = 32'h0000_0057; spsr_we = 1'b1;
        tick(); spsr_we = 1'b0;
        sread(C_SVC, v); chk("R6 svc spsr", v, 32'h53);
        sread(C_ABT, v); chk("R6 abt spsr", v, 32'h57);
        mode_i = C_USR; spsr_wdata = 32'hFFFF_FFFF; spsr_we = 1'b1;
        tick(); spsr_we = 1'b0;
        mode_i = C_SYS; spsr_wdata = 32'hEEEE_EEEE; spsr_we = 1'b1;
        tick(); spsr_we = 1'b0;
        sread(C_USR, v); chk("R6 usr spsr zero", v, 0);
        sread(C_SYS, v); chk("R6 sys spsr zero", v, 0);
        sread(C_SVC, v); chk("R6 svc unchanged", v, 32'h53);
        sread(C_ABT, v); chk("R6 abt unchanged", v, 32'h57);
        sread(C_FIQ, v); chk("R6 fiq unchanged", v, 0);
        sread(C_IRQ, v); chk("R6 irq unchanged", v, 0);
        sread(C_UND, v); chk("R6 und unchanged", v, 0);
    endtask

    task automatic t_mode_err();
        logic [31:0] v;
        mode_i = C_FIQ; #1; chk("R7 legal no err", 32'(mode_err), 0);
        gread(C_BAD, 4'd13, v);
        chk("R7 err flag", 32'(mode_err), 1);
        chk("R7 illegal uses common sp", v, 32'h5555_0013);
        gread(C_BAD, 4'd10, v); chk("R7 illegal uses common r10", v, 32'hAAAA_0010);
        sread(C_BAD, v); chk("R7 illegal spsr zero", v, 0);
        mode_i = C_SYS; #1; chk("R7 sys no err", 32'(mode_err), 0);
    endtask

    task automatic t_side();
        logic [31:0] v;
        mode_i = C_USR;
        xspsr_we = 1'b1; xspsr_mode = C_IRQ; xspsr_wdata = 32'h0000_1D12;
        tick();
        xspsr_we = 1'b0; mode_i = C_IRQ;
        #1; chk("R8 irq spsr via side", spsr_rdata, 32'h1D12);
        xspsr_we = 1'b1; xspsr_mode = C_SYS; xspsr_wdata = 32'h9999_9999;
        tick();
        xspsr_mode = C_BAD;
        tick();
        xspsr_we = 1'b0;
        sread(C_IRQ, v); chk("R8 irq kept", v, 32'h1D12);
        sread(C_SVC, v); chk("R8 svc kept", v, 32'h53);
        sread(C_FIQ, v); chk("R8 fiq kept", v, 0);
        sread(C_UND, v); chk("R8 und kept", v, 0);
        sread(C_ABT, v); chk("R8 abt kept", v, 32'h57);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        mode_i = C_SVC;
        spsr_we = 1'b1; spsr_wdata = 32'h0000_AAAA;
        xspsr_we = 1'b1; xspsr_mode = C_SVC; xspsr_wdata = 32'h0000_BBBB;
        tick();
        spsr_we = 1'b0; xspsr_we = 1'b0;
        sread(C_SVC, v); chk("R9 side port wins", v, 32'hBBBB);
        mode_i = C_ABT;
        spsr_we = 1'b1; spsr_wdata = 32'h0000_0AB7;
        xspsr_we = 1'b1; xspsr_mode = C_UND; xspsr_wdata = 32'h0000_0D1B;
        tick();
        spsr_we = 1'b0; xspsr_we = 1'b0;
        sread(C_ABT, v); chk("R9 both abt", v, 32'h0AB7);
        sread(C_UND, v); chk("R9 both und", v, 32'h0D1B);
    endtask

    task automatic t_cpsr();
        mode_i = C_USR; cpsr_we = 1'b1; cpsr_wdata = 32'h0000_01D0;
        tick(); cpsr_we = 1'b0;
        mode_i = C_FIQ; #1; chk("R10 cpsr in fiq", cpsr_rdata, 32'h01D0);
        mode_i = C_UND; cpsr_we = 1'b1; cpsr_wdata = 32'h0000_00DB;
        tick(); cpsr_we = 1'b0;
        mode_i = C_SYS; #1; chk("R10 cpsr in sys", cpsr_rdata, 32'h00DB);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_shared_low();
        t_fiq_bank();
        t_sp_lr();
        t_dual_read();
        t_spsr();
        t_mode_err();
        t_side();
        t_collide();
        t_cpsr();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule